// File: doc/BRIEF.md
# Bridge Control Register Bank

This block is the word-addressed control and status store of a host bridge. Software reaches it through a simple 32-bit bus: a byte address, a write strobe with write data, and a read-data return that follows the address in the same cycle. Twenty-eight words sit at byte offsets 0x00 through 0x6C. Most of them are plain storage whose contents feed configuration logic elsewhere in the bridge. That logic is not part of this block.

Three words behave differently. The interrupt-enable word cannot be written directly. It changes only through a set alias and a clear alias, and its value is also driven out on a dedicated port. The enable word and the interrupt-status word ignore writes. A write to the general configuration word that raises its reset bit produces a one-cycle system reset request. Every word takes a fixed value at reset. Addresses beyond the last word are inert.

Top module: `ctl_regbank`

## Requirements
- R1: While `rst_n` is low at a clock edge, every word takes its reset value after that edge. The non-zero reset values are: 0x00=0x00000C40, 0x04=0x00001384, 0x08=0x2BFF8010, 0x0C=0x255E0091, 0x10=0x00006140, 0x1C=0x000001FF, 0x20=0x000001FF, 0x68=0x00000008 and 0x6C=0x10000000. All other words, including the enable word, reset to zero.
- R2: The plain words are 0x00–0x2C and 0x40–0x6C. A write to one of them stores `bus_wdata` at the clock edge, and a read of the same address afterwards returns that value.
- R3: A write to 0x30 stores the written value in the word at 0x30. At the same edge it ORs the written value into the enable word, which reads at 0x38.
- R4: A write to 0x34 stores the written value in the word at 0x34. At the same edge it clears every enable bit that is 1 in the written value.
- R5: Writes to 0x38 (enable) and 0x3C (interrupt status) change nothing. A read of 0x3C returns zero.
- R6: Bit 2 of the word at 0x04 is the reset bit. A write to 0x04 that takes this bit from 0 to 1 raises `sys_reset_req` for exactly the one cycle after the write edge. The written value is stored as on any other write.
- R7: `sys_reset_req` stays low in three cases: a write to 0x04 while bit 2 is already 1, a write to 0x04 with bit 2 at 0, and a write with bit 2 set to any other address.
- R8: Writes to byte offsets 0x70 and above change no word, and reads from them return zero.
- R9: `irq_enable` always equals the enable word, which is the value a read of 0x38 returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address; bits 1:0 are ignored |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| irq_enable | output | 32 | Current interrupt-enable word |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The reset image of the bank is read back first, at the initialised words and at several zero words. Distinct data patterns are then written to plain words at both ends of the map, which shows that each word is stored separately.

The enable word is built up through the set alias, then trimmed through the clear alias. Direct writes to the enable word are expected to leave it unchanged, which separates it from a plain register. The reset bit is driven through four cases: already set, cleared, raised, and raised again. A write with bit 2 set goes to a neighbouring word, which separates a true rising-edge detector from a level or address-blind one.

Writes just past the map, and at an index that would alias word 0 if the index were truncated, confirm that out-of-range accesses touch nothing.

// File: rtl/ctl_regbank_pkg.sv
// Package: ctl_regbank_pkg
// Shared map constants and the reset image of the bridge control bank.
// Assumes 32-bit words; indices are byte offsets divided by four.
package ctl_regbank_pkg;

    localparam int NUM_WORDS   = 28;
    localparam int IDX_GENCFG  = 1;   // general configuration (reset bit)
    localparam int IDX_EN_SET  = 12;  // enable set alias
    localparam int IDX_EN_CLR  = 13;  // enable clear alias
    localparam int IDX_EN      = 14;  // enable word (read only)
    localparam int IDX_STAT    = 15;  // interrupt status (read only)
    localparam int RST_BIT     = 2;   // bit of IDX_GENCFG that requests reset

    // Reset value of a word, by index.
    function automatic logic [31:0] reset_word(input int idx);
        logic [31:0] v;
        case (idx)
            0:       v = 32'h0000_0C40;
            1:       v = 32'h0000_1384;
            2:       v = 32'h2BFF_8010;
            3:       v = 32'h255E_0091;
            4:       v = 32'h0000_6140;
            7:       v = 32'h0000_01FF;
            8:       v = 32'h0000_01FF;
            26:      v = 32'h0000_0008;
            27:      v = 32'h1000_0000;
            default: v = 32'h0000_0000;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/ctl_regbank_decode.sv
// Module: ctl_regbank_decode
// Turns a byte address and a write strobe into a one-hot write select and
// an in-range flag. Assumes word-aligned access; address bits 1:0 are dropped.
module ctl_regbank_decode #(
    parameter int ADDR_W    = 8,
    parameter int NUM_WORDS = 28,
    localparam int IDX_W    = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr,
    output logic [IDX_W-1:0]     idx,
    output logic                 in_range,
    output logic [NUM_WORDS-1:0] wsel
);

    assign idx      = addr[ADDR_W-1:2];
    assign in_range = ({1'b0, idx} < (IDX_W+1)'(NUM_WORDS));

    // One write select per word, only for in-range addresses.
    genvar g;
    generate
        for (g = 0; g < NUM_WORDS; g++) begin : g_sel
            assign wsel[g] = wr && in_range && (idx == IDX_W'(g));
        end
    endgenerate

endmodule

// File: rtl/ctl_word_store.sv
// Module: ctl_word_store
// Plain storage for every word of the bank except the enable and status
// words, which are held at zero here and served by their own logic.
// Assumes at most one write select is active per cycle.
module ctl_word_store
    import ctl_regbank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_WORDS-1:0]             wsel,
    input  logic [DATA_W-1:0]                wdata,
    output logic [NUM_WORDS-1:0][DATA_W-1:0] words
);

    genvar g;
    generate
        for (g = 0; g < NUM_WORDS; g++) begin : g_word
            if (g == IDX_EN || g == IDX_STAT) begin : g_ro
                assign words[g] = '0;
            end else begin : g_rw
                // Load the reset image, else capture a selected write.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        words[g] <= DATA_W'(reset_word(g));
                    end else if (wsel[g]) begin
                        words[g] <= wdata;
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/ctl_irq_enable.sv
// Module: ctl_irq_enable
// Interrupt-enable word, changed only through the set and clear aliases.
// Assumes set and clear never fire in the same cycle (one-hot decode).
module ctl_irq_enable #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_hit,
    input  logic              clr_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] en
);

    // OR in on a set write, mask out on a clear write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= '0;
        end else if (set_hit) begin
            en <= en | wdata;
        end else if (clr_hit) begin
            en <= en & ~wdata;
        end
    end

endmodule

// File: rtl/ctl_reset_trigger.sv
// Module: ctl_reset_trigger
// Emits a one-cycle request when a write raises the reset bit from 0 to 1.
// Assumes old_bit is the stored bit before the same edge that stores new_bit.
module ctl_reset_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic old_bit,
    input  logic new_bit,
    output logic req
);

    // Register the 0-to-1 condition of the write into a single pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= 1'b0;
        end else begin
            req <= hit && !old_bit && new_bit;
        end
    end

endmodule

// File: rtl/ctl_regbank.sv
// Module: ctl_regbank
// Bridge control register bank: decode, plain storage, alias-driven enable
// word, reset-bit edge trigger and the read multiplexer.
// Assumes a 32-bit single-beat bus; reads are combinational on bus_addr.
module ctl_regbank
    import ctl_regbank_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] irq_enable,
    output logic              sys_reset_req
);

    logic [IDX_W-1:0]                 idx;
    logic                             in_range;
    logic [NUM_WORDS-1:0]             wsel;
    logic [NUM_WORDS-1:0][DATA_W-1:0] words;
    logic [DATA_W-1:0]                en_word;

    ctl_regbank_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_WORDS (NUM_WORDS)
    ) u_dec (
        .addr     (bus_addr),
        .wr       (bus_wr),
        .idx      (idx),
        .in_range (in_range),
        .wsel     (wsel)
    );

    ctl_word_store #(
        .DATA_W (DATA_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wsel  (wsel),
        .wdata (bus_wdata),
        .words (words)
    );

    ctl_irq_enable #(
        .DATA_W (DATA_W)
    ) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_hit (wsel[IDX_EN_SET]),
        .clr_hit (wsel[IDX_EN_CLR]),
        .wdata   (bus_wdata),
        .en      (en_word)
    );

    ctl_reset_trigger u_rst (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (wsel[IDX_GENCFG]),
        .old_bit (words[IDX_GENCFG][RST_BIT]),
        .new_bit (bus_wdata[RST_BIT]),
        .req     (sys_reset_req)
    );

    assign irq_enable = en_word;

    // Select the addressed word; out-of-range and status read as zero.
    always_comb begin
        bus_rdata = '0;
        if (in_range) begin
            if (idx == IDX_W'(IDX_EN)) begin
                bus_rdata = en_word;
            end else begin
                bus_rdata = words[idx];
            end
        end
    end

endmodule

// File: rtl/ctl_regbank_chk.sv
// Module: ctl_regbank_chk
// Port-level properties of the register bank, bound to every instance.
module ctl_regbank_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] irq_enable,
    input logic              sys_reset_req
);
    localparam int IDX_W = ADDR_W - 2;
    logic [IDX_W-1:0] w_idx;
    assign w_idx = bus_addr[ADDR_W-1:2];

    assert_en_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && w_idx == IDX_W'(12)) |=>
        (irq_enable == ($past(irq_enable) | $past(bus_wdata))));

    assert_en_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && w_idx == IDX_W'(13)) |=>
        (irq_enable == ($past(irq_enable) & ~$past(bus_wdata))));

    assert_ro_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (w_idx == IDX_W'(14) || w_idx == IDX_W'(15))) |=>
        $stable(irq_enable));

    assert_req_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |->
        ($past(bus_wr) && $past(w_idx) == IDX_W'(1) && $past(bus_wdata[2])));

    assert_req_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |=> !sys_reset_req);

    assert_oob_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, w_idx} >= (IDX_W+1)'(28)) |-> (bus_rdata == '0));

    assert_en_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (w_idx == IDX_W'(14)) |-> (bus_rdata == irq_enable));

endmodule

bind ctl_regbank ctl_regbank_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .irq_enable    (irq_enable),
    .sys_reset_req (sys_reset_req)
);

// File: tb/tb_ctl_regbank.sv
`timescale 1ns/1ps
module tb_ctl_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_enable;
    logic        sys_reset_req;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ctl_regbank dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_addr      (bus_addr),
        .bus_wr        (bus_wr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .irq_enable    (irq_enable),
        .sys_reset_req (sys_reset_req)
    );

    // wr=1: write data, expect sys_reset_req==exp_req after the edge.
    // wr=0: read addr, expect bus_rdata==data.
    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic        exp_req;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 43;
    localparam vec_t VECS [NV] = '{
        // R1 reset image
        '{1'b0, 8'h00, 32'h0000_0C40, 1'b0, 4'd1},
        '{1'b0, 8'h04, 32'h0000_1384, 1'b0, 4'd1},
        '{1'b0, 8'h08, 32'h2BFF_8010, 1'b0, 4'd1},
        '{1'b0, 8'h0C, 32'h255E_0091, 1'b0, 4'd1},
        '{1'b0, 8'h10, 32'h0000_6140, 1'b0, 4'd1},
        '{1'b0, 8'h1C, 32'h0000_01FF, 1'b0, 4'd1},
        '{1'b0, 8'h20, 32'h0000_01FF, 1'b0, 4'd1},
        '{1'b0, 8'h68, 32'h0000_0008, 1'b0, 4'd1},
        '{1'b0, 8'h6C, 32'h1000_0000, 1'b0, 4'd1},
        '{1'b0, 8'h38, 32'h0000_0000, 1'b0, 4'd1},
        '{1'b0, 8'h14, 32'h0000_0000, 1'b0, 4'd1},
        '{1'b0, 8'h40, 32'h0000_0000, 1'b0, 4'd1},
        // R2 plain storage
        '{1'b1, 8'h14, 32'hA5A5_5A5A, 1'b0, 4'd2},
        '{1'b0, 8'h14, 32'hA5A5_5A5A, 1'b0, 4'd2},
        '{1'b1, 8'h48, 32'hDEAD_BEEF, 1'b0, 4'd2},
        '{1'b0, 8'h48, 32'hDEAD_BEEF, 1'b0, 4'd2},
        '{1'b1, 8'h6C, 32'h0000_1234, 1'b0, 4'd2},
        '{1'b0, 8'h6C, 32'h0000_1234, 1'b0, 4'd2},
        // R3 set alias
        '{1'b1, 8'h30, 32'h0000_00F0, 1'b0, 4'd3},
        '{1'b0, 8'h38, 32'h0000_00F0, 1'b0, 4'd3},
        '{1'b0, 8'h30, 32'h0000_00F0, 1'b0, 4'd3},
        '{1'b1, 8'h30, 32'h0000_0F00, 1'b0, 4'd3},
        '{1'b0, 8'h38, 32'h0000_0FF0, 1'b0, 4'd3},
        // R4 clear alias
        '{1'b1, 8'h34, 32'h0000_0030, 1'b0, 4'd4},
        '{1'b0, 8'h38, 32'h0000_0FC0, 1'b0, 4'd4},
        '{1'b0, 8'h34, 32'h0000_0030, 1'b0, 4'd4},
        // R5 read-only words
        '{1'b1, 8'h38, 32'hFFFF_FFFF, 1'b0, 4'd5},
        '{1'b0, 8'h38, 32'h0000_0FC0, 1'b0, 4'd5},
        '{1'b1, 8'h3C, 32'h0000_0001, 1'b0, 4'd5},
        '{1'b0, 8'h3C, 32'h0000_0000, 1'b0, 4'd5},
        // R6 / R7 reset bit
        '{1'b1, 8'h04, 32'h0000_1384, 1'b0, 4'd7},
        '{1'b1, 8'h04, 32'h0000_0000, 1'b0, 4'd7},
        '{1'b0, 8'h04, 32'h0000_0000, 1'b0, 4'd6},
        '{1'b1, 8'h04, 32'h0000_0004, 1'b1, 4'd6},
        '{1'b0, 8'h04, 32'h0000_0004, 1'b0, 4'd6},
        '{1'b1, 8'h04, 32'h0000_0004, 1'b0, 4'd7},
        '{1'b1, 8'h08, 32'h0000_0004, 1'b0, 4'd7},
        '{1'b0, 8'h08, 32'h0000_0004, 1'b0, 4'd2},
        // R8 out of range
        '{1'b1, 8'h70, 32'hFFFF_FFFF, 1'b0, 4'd8},
        '{1'b0, 8'h70, 32'h0000_0000, 1'b0, 4'd8},
        '{1'b0, 8'hFC, 32'h0000_0000, 1'b0, 4'd8},
        '{1'b1, 8'h80, 32'h0000_0055, 1'b0, 4'd8},
        '{1'b0, 8'h00, 32'h0000_0C40, 1'b0, 4'd8}
    };

    task automatic check(input bit ok, input int req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d,
                            output logic req_seen);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        req_seen = sys_reset_req;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        logic        r;
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(sys_reset_req == 1'b0, 1, {31'b0, sys_reset_req}, 32'h0); // R1

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                do_write(VECS[i].addr, VECS[i].data, r);
                check(r == VECS[i].exp_req, int'(VECS[i].req),
                      {31'b0, r}, {31'b0, VECS[i].exp_req});
            end else begin
                do_read(VECS[i].addr, d);
                check(d == VECS[i].data, int'(VECS[i].req), d, VECS[i].data);
            end
        end

        // R6: the request lasts exactly one cycle
        do_write(8'h04, 32'h0, r);
        do_write(8'h04, 32'h4, r);
        check(r == 1'b1, 6, {31'b0, r}, 32'h1);
        @(negedge clk);
        bus_wr = 1'b0;
        @(posedge clk);
        #1;
        check(sys_reset_req == 1'b0, 6, {31'b0, sys_reset_req}, 32'h0);

        // R9: enable port mirrors the enable word
        do_read(8'h38, d);
        check(irq_enable == d, 9, irq_enable, d);
        check(irq_enable == 32'h0000_0FC0, 9, irq_enable, 32'h0000_0FC0);

        // R1: reset in the middle of operation restores the image
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(irq_enable == 32'h0, 1, irq_enable, 32'h0);
        do_read(8'h04, d);
        check(d == 32'h0000_1384, 1, d, 32'h0000_1384);
        do_read(8'h14, d);
        check(d == 32'h0, 1, d, 32'h0);
        do_read(8'h30, d);
        check(d == 32'h0, 1, d, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule